// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM alive without help from the access controller. After reset it waits out the power-up pause. It then runs a short burst of warm-up refresh cycles and only after that reports the memory ready. In normal operation a free-running interval timer marks when each distributed refresh is owed. Owed refreshes pile up in a backlog counter until the access controller grants the bus. Each refresh is a CAS-before-RAS cycle, so the device supplies the row itself and no row address is produced.

The scheduler asks for the bus with `req_o` and raises `urgent_o` when the backlog grows large. While `grant_i` is high, its own RAS, CAS and WE drive replaces the controller's strobes at the DRAM pins. A self-refresh request is taken up only between refresh cycles. The block first sweeps every row, then enters self-refresh by holding RAS low for at least the minimum hold. It stays there until the request is withdrawn. After exit it precharges, sweeps every row again and pulses `sweep_done_o`.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and directly after reset, `req_o`, `urgent_o`, `ready_o`, `self_active_o` and `sweep_done_o` are low, and the scheduler's own strobes are all high (inactive).
- R2: `req_o` stays low for exactly `INIT_PAUSE_TICKS` clock edges after reset is released, then rises.
- R3: Exactly `WARMUP_CYCLES` refresh cycles (RAS falling edges) are issued after the pause and before `ready_o` rises. `ready_o` then stays high.
- R4: In every ordinary refresh cycle, all CAS lanes fall together, at least `CSR_TICKS` cycles before RAS falls. CAS stays low for exactly `CHR_TICKS` cycles counted from the RAS fall. RAS is low for exactly `RAS_TICKS` cycles. WE is high at the RAS fall.
- R5: RAS stays high for at least `RP_TICKS` cycles between consecutive refresh cycles.
- R6: Once ready, one refresh becomes owed every `INTERVAL_TICKS` cycles. While any refresh is owed, `req_o` is high. Each granted refresh clears one owed refresh, and `req_o` falls when none remain.
- R7: `urgent_o` is high exactly while the owed count is at least `URGENT_LEVEL`; the owed count never reaches eight with `urgent_o` low.
- R8: With `grant_i` low, the DRAM strobe pins equal the controller's strobe inputs. With `grant_i` high, they carry the scheduler's own drive.
- R9: A self-refresh request is taken only when no refresh cycle is in progress. `SWEEP_ROWS` back-to-back refresh cycles then precede the self-refresh entry cycle.
- R10: In self-refresh, RAS and CAS are held low and `self_active_o` is high for at least `SR_MIN_TICKS` cycles. This holds even if the request is withdrawn early. Exit happens only after the request is withdrawn.
- R11: After self-refresh exit, RAS stays high for at least `SR_RP_TICKS` cycles. Then exactly `SWEEP_ROWS` refresh cycles run, followed by a single-cycle `sweep_done_o` pulse. Normal operation then resumes with nothing owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Bus granted to the scheduler by the access controller |
| self_req_i | input | 1 | Level request to enter and stay in self-refresh |
| ctl_ras_n_i | input | 1 | Access controller RAS strobe |
| ctl_cas_n_i | input | NUM_CAS | Access controller CAS strobes, one per byte lane |
| ctl_we_n_i | input | 1 | Access controller WE strobe |
| req_o | output | 1 | Scheduler needs the bus |
| urgent_o | output | 1 | Refresh backlog has reached the urgent level |
| ready_o | output | 1 | Initialization finished, normal access allowed |
| self_active_o | output | 1 | DRAM is held in self-refresh |
| sweep_done_o | output | 1 | One-cycle pulse when the post-exit sweep completes |
| dram_ras_n_o | output | 1 | RAS pin drive |
| dram_cas_n_o | output | NUM_CAS | CAS pin drive, one per byte lane |
| dram_we_n_o | output | 1 | WE pin drive |

## Verification
The bench builds the block with a 40-cycle refresh interval, a 30-cycle power-up pause, a six-row sweep, a 20-cycle self-refresh minimum and an urgent level of three. At the default sizes, a full sweep, the 100 µs self-refresh hold and the 200 µs pause would be far too long to run. These values make them short enough to walk through completely, several times. The small urgent level lets the backlog reach the flag after three withheld intervals. A pin monitor measures the strobe timing of every refresh cycle the scheduler drives. Directed tasks cover an early withdrawal of the self-refresh request and a request that arrives in the middle of a refresh cycle.

// File: rtl/dram_ref_pkg.sv
// Shared types for the DRAM refresh scheduler.
// Assumes: strobes are active low; one CAS value is fanned out to every lane.
package dram_ref_pkg;

    // Scheduler operating phase.
    typedef enum logic [2:0] {
        PH_PAUSE     = 3'd0,
        PH_WARMUP    = 3'd1,
        PH_NORMAL    = 3'd2,
        PH_PRESWEEP  = 3'd3,
        PH_SELF      = 3'd4,
        PH_POSTSWEEP = 3'd5
    } phase_t;

    // Refresh cycle sequencer step.
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_LEAD  = 3'd1,
        SQ_CHOLD = 3'd2,
        SQ_RHOLD = 3'd3,
        SQ_SELF  = 3'd4,
        SQ_PRE   = 3'd5
    } seq_t;

    // Strobe drive produced by the scheduler itself.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

endpackage

// File: rtl/ref_interval_timer.sv
// Free-running refresh interval timer.
// Emits one tick every INTERVAL_TICKS cycles while run_i is high and
// restarts from zero whenever run_i drops.
// Assumes: INTERVAL_TICKS >= 2.
module ref_interval_timer #(
    parameter int INTERVAL_TICKS = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int TW = $clog2(INTERVAL_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_TICKS - 1);

    logic [TW-1:0] cnt_q;

    // Tick when the count reaches the end of an interval.
    assign tick_o = run_i && (cnt_q == LAST);

    // Advance the interval count; wrap at the end, clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: ticks are separated by a full interval, never adjacent.
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/ref_backlog.sv
// Saturating count of owed refreshes with an urgent flag.
// Assumes: URGENT_LEVEL lies between 1 and 8 so urgency shows before eight.
module ref_backlog #(
    parameter int PEND_W       = 4,
    parameter int URGENT_LEVEL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              owe_i,
    input  logic              paid_i,
    output logic [PEND_W-1:0] level_o,
    output logic              urgent_o
);
    localparam logic [PEND_W-1:0] FULL = '1;

    logic [PEND_W-1:0] level_q;

    // Add owed refreshes, remove granted ones, hold at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            level_q <= '0;
        end else begin
            case ({owe_i, paid_i})
                2'b10:   if (level_q != FULL) level_q <= level_q + 1'b1;
                2'b01:   if (level_q != '0)   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign level_o  = level_q;
    assign urgent_o = int'(level_q) >= URGENT_LEVEL;

    // R7: a backlog of eight or more is never left without the urgent flag.
    a_r7_urgent_by_eight: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_o) >= 8) |-> urgent_o);

    // R7: the count never wraps from full to empty on an owed tick.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == FULL && owe_i && !paid_i && !clear_i) |=> (level_o == FULL));

endmodule

// File: rtl/cbr_cycle_seq.sv
// Sequencer for one CAS-before-RAS refresh cycle.
// Order: CAS low, RAS low, CAS high (or stays low in self-refresh),
// RAS high, precharge. In self-refresh RAS is held for at least
// SR_MIN_TICKS and released once wake_i is seen.
// Assumes: all tick parameters >= 1 and RAS_TICKS > CHR_TICKS.
module cbr_cycle_seq
    import dram_ref_pkg::*;
#(
    parameter int CSR_TICKS    = 1,
    parameter int CHR_TICKS    = 1,
    parameter int RAS_TICKS    = 7,
    parameter int RP_TICKS     = 4,
    parameter int SR_MIN_TICKS = 12600,
    parameter int SR_RP_TICKS  = 12
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    self_i,
    input  logic    wake_i,
    output logic    idle_o,
    output logic    done_o,
    output logic    in_self_o,
    output strobe_t drive_o
);
    localparam int CW = $clog2(CSR_TICKS + CHR_TICKS + RAS_TICKS + RP_TICKS
                               + SR_MIN_TICKS + SR_RP_TICKS + 1);
    localparam int LW = $clog2(SR_MIN_TICKS + RAS_TICKS + CHR_TICKS + 2) + 1;

    seq_t          st_q;
    logic [CW-1:0] cnt_q;
    logic          self_q;
    logic          ras_n_w;
    logic          cas_n_w;

    // Step through the refresh cycle, each step timed by the down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            cnt_q  <= '0;
            self_q <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: if (start_i) begin
                    st_q   <= SQ_LEAD;
                    cnt_q  <= CW'(CSR_TICKS - 1);
                    self_q <= self_i;
                end
                SQ_LEAD: if (cnt_q == '0) begin
                    st_q  <= SQ_CHOLD;
                    cnt_q <= CW'(CHR_TICKS - 1);
                end else cnt_q <= cnt_q - 1'b1;
                SQ_CHOLD: if (cnt_q == '0) begin
                    if (self_q) begin
                        st_q  <= SQ_SELF;
                        cnt_q <= CW'(SR_MIN_TICKS - 1);
                    end else begin
                        st_q  <= SQ_RHOLD;
                        cnt_q <= CW'(RAS_TICKS - CHR_TICKS - 1);
                    end
                end else cnt_q <= cnt_q - 1'b1;
                SQ_RHOLD: if (cnt_q == '0) begin
                    st_q  <= SQ_PRE;
                    cnt_q <= CW'(RP_TICKS - 1);
                end else cnt_q <= cnt_q - 1'b1;
                SQ_SELF: if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (wake_i) begin
                    st_q  <= SQ_PRE;
                    cnt_q <= CW'(SR_RP_TICKS - 1);
                end
                SQ_PRE: if (cnt_q == '0) begin
                    st_q <= SQ_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Decode the strobe levels from the current step.
    always_comb begin
        ras_n_w = !(st_q == SQ_CHOLD || st_q == SQ_RHOLD || st_q == SQ_SELF);
        cas_n_w = !(st_q == SQ_LEAD || st_q == SQ_CHOLD || st_q == SQ_SELF);
    end

    assign drive_o   = '{ras_n: ras_n_w, cas_n: cas_n_w, we_n: 1'b1};
    assign idle_o    = (st_q == SQ_IDLE);
    assign in_self_o = (st_q == SQ_SELF);
    assign done_o    = (st_q == SQ_PRE) && (cnt_q == '0);

    // Checker state: length of the current RAS-low stretch.
    logic [LW-1:0] low_len_q;

    // Count edges with RAS low; saturate; clear while RAS is high.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n_w) begin
            low_len_q <= '0;
        end else if (low_len_q != '1) begin
            low_len_q <= low_len_q + 1'b1;
        end
    end

    // R4: CAS is already low, and stays low, when RAS falls.
    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_w) |-> (!cas_n_w && !$past(cas_n_w)));

    // R10: a self-refresh stretch lasts at least the minimum hold.
    a_r10_self_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n_w) && $past(in_self_o)) |->
            (int'(low_len_q) >= SR_MIN_TICKS + CHR_TICKS));

    // R5: once RAS rises it stays high for the next cycle too.
    a_r5_precharge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_w) |=> ras_n_w);

endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh and initialization scheduler (top).
// Runs the power-up pause and warm-up refreshes, distributed CBR refresh
// with a backlog and urgent flag, and self-refresh entry and exit with a
// full sweep on each side. The scheduler's strobes replace the access
// controller's at the pins while grant_i is high.
// Assumes: the controller keeps grant_i high until req_o falls.
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int NUM_CAS          = 2,
    parameter int INTERVAL_TICKS   = 1950,
    parameter int INIT_PAUSE_TICKS = 25000,
    parameter int WARMUP_CYCLES    = 8,
    parameter int SWEEP_ROWS       = 4096,
    parameter int CSR_TICKS        = 1,
    parameter int CHR_TICKS        = 1,
    parameter int RAS_TICKS        = 7,
    parameter int RP_TICKS         = 4,
    parameter int SR_MIN_TICKS     = 12600,
    parameter int SR_RP_TICKS      = 12,
    parameter int PEND_W           = 4,
    parameter int URGENT_LEVEL     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_i,
    input  logic               self_req_i,
    input  logic               ctl_ras_n_i,
    input  logic [NUM_CAS-1:0] ctl_cas_n_i,
    input  logic               ctl_we_n_i,
    output logic               req_o,
    output logic               urgent_o,
    output logic               ready_o,
    output logic               self_active_o,
    output logic               sweep_done_o,
    output logic               dram_ras_n_o,
    output logic [NUM_CAS-1:0] dram_cas_n_o,
    output logic               dram_we_n_o
);
    localparam int PCW     = $clog2(INIT_PAUSE_TICKS + 1);
    localparam int CYC_MAX = (SWEEP_ROWS > WARMUP_CYCLES) ? SWEEP_ROWS : WARMUP_CYCLES;
    localparam int CCW     = $clog2(CYC_MAX + 1);
    localparam logic [PCW-1:0] PAUSE_LAST = PCW'(INIT_PAUSE_TICKS - 1);
    localparam logic [CCW-1:0] WARM_LAST  = CCW'(WARMUP_CYCLES - 1);
    localparam logic [CCW-1:0] SWEEP_LAST = CCW'(SWEEP_ROWS - 1);
    localparam logic [CCW-1:0] SWEEP_ALL  = CCW'(SWEEP_ROWS);

    phase_t            phase_q;
    logic [PCW-1:0]    pause_q;
    logic [CCW-1:0]    cyc_q;
    logic              ready_q;
    logic              sweep_done_q;

    logic              tick_w;
    logic [PEND_W-1:0] owed_w;
    logic              seq_start;
    logic              seq_self;
    logic              seq_idle;
    logic              seq_done;
    logic              seq_in_self;
    strobe_t           own_w;

    ref_interval_timer #(
        .INTERVAL_TICKS(INTERVAL_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (phase_q == PH_NORMAL),
        .tick_o(tick_w)
    );

    ref_backlog #(
        .PEND_W      (PEND_W),
        .URGENT_LEVEL(URGENT_LEVEL)
    ) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (phase_q != PH_NORMAL),
        .owe_i   (tick_w),
        .paid_i  (seq_done && phase_q == PH_NORMAL),
        .level_o (owed_w),
        .urgent_o(urgent_o)
    );

    cbr_cycle_seq #(
        .CSR_TICKS   (CSR_TICKS),
        .CHR_TICKS   (CHR_TICKS),
        .RAS_TICKS   (RAS_TICKS),
        .RP_TICKS    (RP_TICKS),
        .SR_MIN_TICKS(SR_MIN_TICKS),
        .SR_RP_TICKS (SR_RP_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (seq_start),
        .self_i   (seq_self),
        .wake_i   (!self_req_i),
        .idle_o   (seq_idle),
        .done_o   (seq_done),
        .in_self_o(seq_in_self),
        .drive_o  (own_w)
    );

    // Decide when a refresh cycle may start and whether it enters self-refresh.
    always_comb begin
        seq_self = (phase_q == PH_PRESWEEP) && (cyc_q == SWEEP_ALL);
        case (phase_q)
            PH_WARMUP:    seq_start = grant_i && seq_idle;
            PH_NORMAL:    seq_start = grant_i && seq_idle && !self_req_i && (owed_w != '0);
            PH_PRESWEEP:  seq_start = grant_i && seq_idle;
            PH_POSTSWEEP: seq_start = grant_i && seq_idle;
            default:      seq_start = 1'b0;
        endcase
    end

    // Advance the operating phase and count the cycles of each burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_PAUSE;
            pause_q      <= '0;
            cyc_q        <= '0;
            ready_q      <= 1'b0;
            sweep_done_q <= 1'b0;
        end else begin
            sweep_done_q <= 1'b0;
            case (phase_q)
                PH_PAUSE: begin
                    pause_q <= pause_q + 1'b1;
                    if (pause_q == PAUSE_LAST) begin
                        phase_q <= PH_WARMUP;
                        cyc_q   <= '0;
                    end
                end
                PH_WARMUP: if (seq_done) begin
                    if (cyc_q == WARM_LAST) begin
                        phase_q <= PH_NORMAL;
                        ready_q <= 1'b1;
                        cyc_q   <= '0;
                    end else cyc_q <= cyc_q + 1'b1;
                end
                PH_NORMAL: if (self_req_i && seq_idle) begin
                    phase_q <= PH_PRESWEEP;
                    cyc_q   <= '0;
                end
                PH_PRESWEEP: begin
                    if (seq_done) cyc_q <= cyc_q + 1'b1;
                    if (seq_start && seq_self) phase_q <= PH_SELF;
                end
                PH_SELF: if (seq_done) begin
                    phase_q <= PH_POSTSWEEP;
                    cyc_q   <= '0;
                end
                PH_POSTSWEEP: if (seq_done) begin
                    if (cyc_q == SWEEP_LAST) begin
                        phase_q      <= PH_NORMAL;
                        sweep_done_q <= 1'b1;
                        cyc_q        <= '0;
                    end else cyc_q <= cyc_q + 1'b1;
                end
                default: phase_q <= PH_PAUSE;
            endcase
        end
    end

    // Ask for the bus whenever a refresh is owed or a burst is running.
    always_comb begin
        case (phase_q)
            PH_PAUSE:  req_o = 1'b0;
            PH_NORMAL: req_o = (owed_w != '0) || !seq_idle;
            default:   req_o = 1'b1;
        endcase
    end

    assign ready_o       = ready_q;
    assign sweep_done_o  = sweep_done_q;
    assign self_active_o = seq_in_self;

    // Pin mux for the single-bit strobes: own drive while granted.
    always_comb begin
        dram_ras_n_o = grant_i ? own_w.ras_n : ctl_ras_n_i;
        dram_we_n_o  = grant_i ? own_w.we_n  : ctl_we_n_i;
    end

    // One mux per CAS lane; every lane carries the same own CAS value.
    for (genvar g = 0; g < NUM_CAS; g++) begin : g_cas_lane
        assign dram_cas_n_o[g] = grant_i ? own_w.cas_n : ctl_cas_n_i[g];
    end

    // R6: an owed refresh in normal operation always requests the bus.
    a_r6_req_while_owed: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && owed_w != '0) |-> req_o);

    // R3: once ready, the scheduler stays ready.
    a_r3_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R11: the sweep completion flag is a single-cycle pulse.
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done_o |=> !sweep_done_o);

    // R9: self-refresh is entered only from the pre-entry sweep phase.
    a_r9_self_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_active_o) |-> (phase_q == PH_SELF));

endmodule

// File: tb/tb_dram_refresh_sched.sv
// Directed bench for the DRAM refresh scheduler.
module tb_dram_refresh_sched;
    localparam int N_CAS   = 2;
    localparam int T_INT   = 40;
    localparam int T_PAUSE = 30;
    localparam int T_WARM  = 8;
    localparam int T_SWEEP = 6;
    localparam int T_CSR   = 1;
    localparam int T_CHR   = 1;
    localparam int T_RAS   = 3;
    localparam int T_RP    = 2;
    localparam int T_SRMIN = 20;
    localparam int T_SRRP  = 3;
    localparam int T_URG   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic allow = 1'b1;
    logic self_req = 1'b0;
    logic c_ras = 1'b1;
    logic [N_CAS-1:0] c_cas = '1;
    logic c_we = 1'b1;
    logic req, urgent, ready, self_active, sweep_done, p_ras, p_we;
    logic [N_CAS-1:0] p_cas;

    int total = 0;
    int bad = 0;
    int falls = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .NUM_CAS(N_CAS), .INTERVAL_TICKS(T_INT), .INIT_PAUSE_TICKS(T_PAUSE),
        .WARMUP_CYCLES(T_WARM), .SWEEP_ROWS(T_SWEEP), .CSR_TICKS(T_CSR),
        .CHR_TICKS(T_CHR), .RAS_TICKS(T_RAS), .RP_TICKS(T_RP),
        .SR_MIN_TICKS(T_SRMIN), .SR_RP_TICKS(T_SRRP), .PEND_W(4),
        .URGENT_LEVEL(T_URG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .self_req_i(self_req),
        .ctl_ras_n_i(c_ras), .ctl_cas_n_i(c_cas), .ctl_we_n_i(c_we),
        .req_o(req), .urgent_o(urgent), .ready_o(ready),
        .self_active_o(self_active), .sweep_done_o(sweep_done),
        .dram_ras_n_o(p_ras), .dram_cas_n_o(p_cas), .dram_we_n_o(p_we)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Access controller model: grants shortly after each edge when allowed.
    initial begin
        forever begin
            @(posedge clk);
            #2 grant = allow && req;
        end
    end

    // Pin monitor: measures every refresh cycle driven by the scheduler.
    initial begin
        bit pr, sr_seen, post_sr, cas_gone;
        int hi_run, lead_run, lo_run, cas_hold;
        pr = 1; hi_run = 1000; lead_run = 0; lo_run = 0; cas_hold = 0;
        sr_seen = 0; post_sr = 0; cas_gone = 0;
        forever begin
            @(negedge clk);
            if (!rst_n || !grant) begin
                pr = 1; hi_run = 1000; lead_run = 0; post_sr = 0;
            end else begin
                bit cl;
                cl = (p_cas == '0);
                if (p_cas != '0 && p_cas != '1)
                    chk("R4 lanes differ", 0, int'(p_cas), 0);
                if (pr && p_ras) begin
                    hi_run++;
                    lead_run = cl ? lead_run + 1 : 0;
                end else if (pr && !p_ras) begin
                    falls++;
                    chk("R4 cas lead", cl && lead_run >= T_CSR, lead_run, T_CSR);
                    chk("R4 we high", p_we == 1'b1, int'(p_we), 1);
                    if (post_sr) chk("R11 exit precharge", hi_run >= T_SRRP, hi_run, T_SRRP);
                    else         chk("R5 precharge", hi_run >= T_RP, hi_run, T_RP);
                    lo_run = 1; cas_hold = cl ? 1 : 0; cas_gone = !cl;
                    sr_seen = self_active; post_sr = 0;
                end else if (!pr && !p_ras) begin
                    lo_run++;
                    if (cl && !cas_gone) cas_hold++; else cas_gone = 1;
                    sr_seen = sr_seen | self_active;
                end else begin
                    if (sr_seen) begin
                        chk("R10 self hold", lo_run >= T_SRMIN + T_CHR, lo_run, T_SRMIN + T_CHR);
                    end else begin
                        chk("R4 ras width", lo_run == T_RAS, lo_run, T_RAS);
                        chk("R4 cas hold", cas_hold == T_CHR, cas_hold, T_CHR);
                    end
                    post_sr = sr_seen;
                    hi_run = 1; lead_run = cl ? 1 : 0;
                end
                pr = p_ras;
            end
        end
    end

    // R1, R8: reset state and pass-through of controller strobes.
    task automatic t_reset();
        c_ras = 0; c_cas = 2'b10; c_we = 0;
        ticks(3);
        chk("R1 outputs idle", {req, urgent, ready, self_active, sweep_done} == 5'b0,
            int'({req, urgent, ready, self_active, sweep_done}), 0);
        chk("R8 pass ras", p_ras == 1'b0, int'(p_ras), 0);
        chk("R8 pass cas", p_cas == 2'b10, int'(p_cas), 2);
        chk("R8 pass we", p_we == 1'b0, int'(p_we), 0);
        c_ras = 1; c_cas = '1; c_we = 1;
    endtask

    // R2: request appears exactly after the pause.
    task automatic t_pause();
        int n = 0;
        rst_n = 1;
        while (!req && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R2 pause length", n == T_PAUSE, n, T_PAUSE);
    endtask

    // R3: warm-up cycle count before ready.
    task automatic t_warm();
        int f0 = falls, n = 0;
        while (!ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 warm-up cycles", falls - f0 == T_WARM, falls - f0, T_WARM);
    endtask

    // R6: one refresh per interval in steady state.
    task automatic t_normal();
        int f0 = falls;
        ticks(5 * T_INT + 10);
        chk("R6 refreshes in five intervals", falls - f0 == 5, falls - f0, 5);
        chk("R6 req idle when nothing owed", req == 1'b0, int'(req), 0);
    endtask

    // R7, R8, R6: backlog while the grant is withheld, then catch-up.
    task automatic t_urgent();
        int n = 0, f0;
        allow = 0;
        while (!req && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R6 req on owed refresh", req == 1'b1, int'(req), 1);
        ticks(T_INT);
        chk("R7 two owed not urgent", urgent == 1'b0, int'(urgent), 0);
        c_ras = 0; c_cas = 2'b01; c_we = 0;
        @(negedge clk);
        chk("R8 ungranted pins follow controller", {p_ras, p_cas, p_we} == 4'b0010,
            int'({p_ras, p_cas, p_we}), 2);
        c_ras = 1; c_cas = '1; c_we = 1;
        ticks(T_INT - 1);
        chk("R7 three owed urgent", urgent == 1'b1, int'(urgent), 1);
        f0 = falls;
        allow = 1;
        ticks(30);
        chk("R6 catch-up count", falls - f0 == 3, falls - f0, 3);
        chk("R7 urgent cleared", urgent == 1'b0, int'(urgent), 0);
        chk("R6 req dropped", req == 1'b0, int'(req), 0);
    endtask

    // R9, R10, R11: full self-refresh entry, long hold, exit and sweep.
    task automatic t_self_long();
        int f0 = falls, n = 0;
        self_req = 1;
        while (!self_active && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R9 sweep before entry", falls - f0 == T_SWEEP + 1, falls - f0, T_SWEEP + 1);
        ticks(T_SRMIN + 10);
        chk("R10 still in self-refresh", self_active == 1'b1, int'(self_active), 1);
        chk("R10 ras held low", p_ras == 1'b0, int'(p_ras), 0);
        self_req = 0;
        n = 0;
        while (self_active && n < 100) begin
            @(negedge clk);
            n++;
        end
        f0 = falls;
        n = 0;
        while (!sweep_done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R11 post-exit sweep", falls - f0 == T_SWEEP, falls - f0, T_SWEEP);
        @(negedge clk);
        chk("R11 done is one cycle", sweep_done == 1'b0, int'(sweep_done), 0);
        chk("R11 nothing owed after sweep", req == 1'b0, int'(req), 0);
        chk("R3 ready kept", ready == 1'b1, int'(ready), 1);
    endtask

    // R9, R10: request raised mid-cycle, withdrawn right after entry.
    task automatic t_self_short();
        int f0, n = 0;
        while (p_ras && n < 200) begin
            @(negedge clk);
            n++;
        end
        f0 = falls;
        self_req = 1;
        n = 0;
        while (!self_active && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R9 mid-cycle request waits", falls - f0 == T_SWEEP + 1, falls - f0, T_SWEEP + 1);
        n = 0;
        while (self_active && n < 200) begin
            n++;
            @(negedge clk);
            self_req = 0;
        end
        chk("R10 minimum hold on early release", n == T_SRMIN, n, T_SRMIN);
        n = 0;
        while (!sweep_done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R11 sweep completes", sweep_done == 1'b1, int'(sweep_done), 1);
    endtask

    initial begin
        t_reset();
        t_pause();
        t_warm();
        t_normal();
        t_urgent();
        t_self_long();
        t_self_short();
        ticks(5);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        ticks(20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule